// File: doc/BRIEF.md
# Delayed-Branch Next-PC Sequencer

This block keeps the program-counter pipeline for a 32-bit core that has one branch delay slot. It holds three addresses: the instruction that executes now (`pc_q`), the one after it (`npc_q`, the delay slot) and the one after that (`nnpc_q`). On every cycle that is not stalled, the decoded control-transfer fields of the instruction at `pc_q` decide how the three addresses move. A redirect changes the address that follows the delay slot, so the delay-slot instruction still runs. A "likely" conditional branch that fails its condition skips its delay slot instead, and the block raises `annul` so that fetch can drop the instruction it has already fetched.

The block also produces the return-address write for linking transfers. The value is the address just past the delay slot. Fetch, decode, the register file and condition evaluation are outside the block. The decoder supplies the transfer kind, the evaluated condition, the offset and index fields, and the register target.

Top module: `dbr_pc_seq`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_q` loads `RESET_VEC`, `npc_q` loads `RESET_VEC+4`, `nnpc_q` loads `RESET_VEC+8`, and `annul` and `link_we` are cleared.
- R2: `kind` is encoded as 0 none, 1 conditional branch, 2 unconditional branch, 3 register-indirect jump, 4 absolute jump. With kind 0 and no stall, one edge moves `npc_q` into `pc_q` and `nnpc_q` into `npc_q`, and adds 4 to `nnpc_q`.
- R3: A conditional branch with `cond_met` high moves `npc_q` into `pc_q` (the delay slot still runs). It loads `npc_q` with the target, which is the old `npc_q` plus the displacement `{offset,2'b00}` sign-extended from its bit 17, and loads `nnpc_q` with the target plus 4.
- R4: A conditional branch with `cond_met` low and `likely` low advances exactly like kind 0.
- R5: A conditional branch with `cond_met` low and `likely` high loads `pc_q` with the old `nnpc_q`, `npc_q` with the old `nnpc_q`+4 and `nnpc_q` with the old `nnpc_q`+8. `annul` is high for the one cycle after that edge and is low after any other edge.
- R6: An unconditional branch redirects like R3 whatever the values of `cond_met` and `likely`.
- R7: An absolute jump redirects to `{npc_q[31:28], jidx, 2'b00}` and ignores `cond_met` and `likely`.
- R8: A register-indirect jump redirects to `reg_tgt` and ignores `cond_met` and `likely`.
- R9: When `link` is high with a nonzero kind and no stall, the next cycle shows `link_we` high and `link_val` equal to the old `nnpc_q` (branch address + 8), whether the transfer is taken or not. Otherwise `link_we` is low.
- R10: While `stall` is high, all three PC registers hold, and `link_we` and `annul` are low on the following cycle.
- R11: A negative offset (bit 15 set) gives a backward target, for example offset 16'hFFFF subtracts 4 from `npc_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Holds the PC registers and suppresses link and annul |
| kind | input | 3 | Control-transfer kind of the instruction at `pc_q` |
| cond_met | input | 1 | Evaluated branch condition |
| likely | input | 1 | Squash the delay slot when a conditional branch falls through |
| link | input | 1 | Write the return address to register 31 |
| offset | input | 16 | Word offset for PC-relative branches |
| jidx | input | 26 | Word index for absolute jumps |
| reg_tgt | input | 32 | Target value for register-indirect jumps |
| pc_q | output | 32 | Address of the executing instruction |
| npc_q | output | 32 | Address of the delay-slot instruction |
| nnpc_q | output | 32 | Address after the delay slot |
| link_we | output | 1 | Return-address write enable |
| link_val | output | 32 | Return address for register 31 |
| annul | output | 1 | Discard the fetched delay-slot instruction |

## Verification
The case that is hardest to reach from the ports is a transfer whose own address is not sequential, such as a branch or a likely branch placed right after a redirect or an annul. In that case `npc_q` is no longer `pc_q`+4, so a design that takes its base from the wrong register gives a wrong target or a wrong link value. Random stimulus picks a new kind on every cycle, so transfers often land back to back, and stalls are mixed in. Directed steps chain an annulled likely branch into a linking absolute jump and a backward branch.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [2:0] {
    XK_NONE   = 3'd0,
    XK_COND   = 3'd1,
    XK_UNCOND = 3'd2,
    XK_JREG   = 3'd3,
    XK_JABS   = 3'd4
  } xfer_kind_e;
endpackage

// File: rtl/pcseq_target.sv
module pcseq_target #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int IDX_W = 26
) (
  input  logic [2:0]       kind,
  input  logic [XLEN-1:0]  npc,
  input  logic [OFF_W-1:0] offset,
  input  logic [IDX_W-1:0] jidx,
  input  logic [XLEN-1:0]  reg_tgt,
  output logic [XLEN-1:0]  target
);
  import pcseq_pkg::*;

  localparam int DISP_W = OFF_W + 2;
  localparam int EXT_W  = XLEN - DISP_W;
  localparam int REG_W  = XLEN - IDX_W - 2;

  logic [XLEN-1:0] disp;
  logic [XLEN-1:0] rel_tgt;
  logic [XLEN-1:0] abs_tgt;

  assign disp    = {{EXT_W{offset[OFF_W-1]}}, offset, 2'b00};
  assign rel_tgt = npc + disp;
  assign abs_tgt = {npc[XLEN-1 -: REG_W], jidx, 2'b00};

  always_comb begin
    case (xfer_kind_e'(kind))
      XK_JREG: target = reg_tgt;
      XK_JABS: target = abs_tgt;
      default: target = rel_tgt;
    endcase
  end
endmodule

// File: rtl/pcseq_decide.sv
module pcseq_decide (
  input  logic [2:0] kind,
  input  logic       cond_met,
  input  logic       likely,
  output logic       redirect,
  output logic       squash
);
  import pcseq_pkg::*;

  always_comb begin
    redirect = 1'b0;
    squash   = 1'b0;
    case (xfer_kind_e'(kind))
      XK_COND: begin
        redirect = cond_met;
        squash   = !cond_met && likely;
      end
      XK_UNCOND, XK_JREG, XK_JABS: redirect = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/dbr_pc_seq.sv
module dbr_pc_seq #(
  parameter int          XLEN      = 32,
  parameter int          OFF_W     = 16,
  parameter int          IDX_W     = 26,
  parameter logic [31:0] RESET_VEC = 32'hBFC0_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stall,
  input  logic [2:0]       kind,
  input  logic             cond_met,
  input  logic             likely,
  input  logic             link,
  input  logic [OFF_W-1:0] offset,
  input  logic [IDX_W-1:0] jidx,
  input  logic [XLEN-1:0]  reg_tgt,
  output logic [XLEN-1:0]  pc_q,
  output logic [XLEN-1:0]  npc_q,
  output logic [XLEN-1:0]  nnpc_q,
  output logic             link_we,
  output logic [XLEN-1:0]  link_val,
  output logic             annul
);
  import pcseq_pkg::*;

  localparam logic [XLEN-1:0] STEP  = XLEN'(4);
  localparam logic [XLEN-1:0] STEP2 = XLEN'(8);
  localparam logic [XLEN-1:0] VEC   = XLEN'(RESET_VEC);

  logic [XLEN-1:0] target;
  logic            redirect;
  logic            squash;
  logic            is_xfer;

  assign is_xfer = (xfer_kind_e'(kind) != XK_NONE);

  pcseq_target #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_target (
    .kind    (kind),
    .npc     (npc_q),
    .offset  (offset),
    .jidx    (jidx),
    .reg_tgt (reg_tgt),
    .target  (target)
  );

  pcseq_decide u_decide (
    .kind     (kind),
    .cond_met (cond_met),
    .likely   (likely),
    .redirect (redirect),
    .squash   (squash)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= VEC;
      npc_q    <= VEC + STEP;
      nnpc_q   <= VEC + STEP2;
      link_we  <= 1'b0;
      link_val <= '0;
      annul    <= 1'b0;
    end else if (stall) begin
      link_we <= 1'b0;
      annul   <= 1'b0;
    end else begin
      link_we <= link && is_xfer;
      if (link && is_xfer) link_val <= nnpc_q;
      annul <= squash;
      if (squash) begin
        pc_q   <= nnpc_q;
        npc_q  <= nnpc_q + STEP;
        nnpc_q <= nnpc_q + STEP2;
      end else if (redirect) begin
        pc_q   <= npc_q;
        npc_q  <= target;
        nnpc_q <= target + STEP;
      end else begin
        pc_q   <= npc_q;
        npc_q  <= nnpc_q;
        nnpc_q <= nnpc_q + STEP;
      end
    end
  end

  // R2
  seq_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && kind == 3'd0) |=> (pc_q == $past(npc_q) && npc_q == $past(nnpc_q)));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(pc_q) && $stable(npc_q) && $stable(nnpc_q) && !link_we && !annul));

  // R5
  annul_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && kind == 3'd1 && !cond_met && likely) |=> (annul && pc_q == $past(nnpc_q)));

  // R9
  link_value_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && link && kind != 3'd0) |=> (link_we && link_val == $past(nnpc_q)));

  // R3
  delay_slot_runs_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && redirect) |=> (pc_q == $past(npc_q) && nnpc_q == npc_q + STEP));
endmodule

// File: tb/test_dbr_pc_seq.sv
module test_dbr_pc_seq;
  localparam logic [31:0] VEC = 32'hBFC0_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic [2:0]  kind = 3'd0;
  logic        cond_met = 1'b0;
  logic        likely = 1'b0;
  logic        link = 1'b0;
  logic [15:0] offset = '0;
  logic [25:0] jidx = '0;
  logic [31:0] reg_tgt = '0;
  logic [31:0] pc_q, npc_q, nnpc_q, link_val;
  logic        link_we, annul;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] m_pc, m_npc, m_nnpc;

  always #5 clk = ~clk;

  dbr_pc_seq #(.RESET_VEC(VEC)) i_dbr_pc_seq (
    .clk(clk), .rst(rst), .stall(stall), .kind(kind), .cond_met(cond_met),
    .likely(likely), .link(link), .offset(offset), .jidx(jidx), .reg_tgt(reg_tgt),
    .pc_q(pc_q), .npc_q(npc_q), .nnpc_q(nnpc_q), .link_we(link_we),
    .link_val(link_val), .annul(annul)
  );

  task automatic check(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] k, input bit c, input bit lz,
                                   input bit st, input logic [15:0] off);
    if (st) return "R10";
    case (k)
      3'd0: return "R2";
      3'd1: if (c) return off[15] ? "R11" : "R3";
            else return lz ? "R5" : "R4";
      3'd2: return "R6";
      3'd3: return "R8";
      3'd4: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic step(input logic [2:0] k, input bit c, input logic [15:0] off,
                      input logic [25:0] ji, input logic [31:0] rt,
                      input bit lk, input bit lz, input bit st);
    logic [31:0] disp, tgt, e_pc, e_npc, e_nnpc;
    bit taken, skip, e_lwe, e_an;
    string tg;
    kind = k; cond_met = c; offset = off; jidx = ji; reg_tgt = rt;
    link = lk; likely = lz; stall = st;
    disp = {{14{off[15]}}, off, 2'b00};
    case (k)
      3'd3: tgt = rt;
      3'd4: tgt = {m_npc[31:28], ji, 2'b00};
      default: tgt = m_npc + disp;
    endcase
    taken = (k == 3'd2) || (k == 3'd3) || (k == 3'd4) || (k == 3'd1 && c);
    skip  = (k == 3'd1) && !c && lz;
    if (st) begin
      e_pc = m_pc; e_npc = m_npc; e_nnpc = m_nnpc;
    end else if (skip) begin
      e_pc = m_nnpc; e_npc = m_nnpc + 4; e_nnpc = m_nnpc + 8;
    end else if (taken) begin
      e_pc = m_npc; e_npc = tgt; e_nnpc = tgt + 4;
    end else begin
      e_pc = m_npc; e_npc = m_nnpc; e_nnpc = m_nnpc + 4;
    end
    e_lwe = !st && lk && (k != 3'd0);
    e_an  = !st && skip;
    tg = tag_of(k, c, lz, st, off);
    @(posedge clk);
    @(negedge clk);
    check({pc_q, npc_q, nnpc_q} === {e_pc, e_npc, e_nnpc}, tg,
          {pc_q, npc_q, nnpc_q}, {e_pc, e_npc, e_nnpc});
    check(annul === e_an, e_an ? "R5" : tg, 96'(annul), 96'(e_an));
    check(link_we === e_lwe, "R9", 96'(link_we), 96'(e_lwe));
    if (e_lwe) check(link_val === m_nnpc, "R9", 96'(link_val), 96'(m_nnpc));
    m_pc = e_pc; m_npc = e_npc; m_nnpc = e_nnpc;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check({pc_q, npc_q, nnpc_q} === {VEC, VEC + 32'd4, VEC + 32'd8}, "R1",
          {pc_q, npc_q, nnpc_q}, {VEC, VEC + 32'd4, VEC + 32'd8});
    check({link_we, annul} === 2'b00, "R1", 96'({link_we, annul}), 96'(0));
    rst = 1'b0;
    m_pc = VEC; m_npc = VEC + 4; m_nnpc = VEC + 8;

    step(3'd0, 0, 16'h0, 26'h0, 32'h0, 0, 0, 0);               // R2
    step(3'd1, 1, 16'h0010, 26'h0, 32'h0, 0, 0, 0);            // R3 forward
    step(3'd1, 0, 16'h0020, 26'h0, 32'h0, 0, 0, 0);            // R4 in delay slot
    step(3'd1, 0, 16'h0030, 26'h0, 32'h0, 1, 1, 0);            // R5 likely squash, R9 link
    step(3'd4, 1, 16'h0, 26'h123_4567, 32'h0, 1, 1, 0);        // R7 right after annul
    step(3'd1, 1, 16'hFFFF, 26'h0, 32'h0, 0, 0, 0);            // R11 backward by 4
    step(3'd1, 1, 16'h8000, 26'h0, 32'h0, 0, 1, 0);            // R11 most negative
    step(3'd2, 0, 16'h0004, 26'h0, 32'h0, 0, 1, 0);            // R6 cond_met/likely ignored
    step(3'd3, 0, 16'h0, 26'h0, 32'h8000_1000, 1, 1, 0);       // R8 with link
    step(3'd4, 1, 16'h0, 26'h3FF_FFFF, 32'h0, 1, 0, 1);        // R10 stalled jump
    step(3'd1, 0, 16'h0, 26'h0, 32'h0, 0, 1, 1);               // R10 stalled likely
    step(3'd0, 0, 16'h0, 26'h0, 32'h0, 1, 0, 0);               // R9 link ignored for kind 0

    for (int i = 0; i < 600; i++) begin
      step(3'($urandom_range(0, 4)), 1'($urandom_range(0, 1)), 16'($urandom()),
           26'($urandom()), $urandom() & 32'hFFFF_FFFC,
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 9) == 0));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule